// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the timing for a raster LCD panel. It divides the logic clock by a programmable value to make a pixel clock. It runs a horizontal counter in pixels and a vertical counter in lines. From these counters it drives horizontal sync, vertical sync, data-enable and an AC-bias toggle for passive panels. It also reports its raw position counters. Software programs three timing registers and a control register through a plain write port: no read path and no bus handshake.

A frame is laid out on each axis in this order: sync, back porch, active region, front porch. Setting the run bit starts a frame from position zero. Clearing the run bit does not cut the output short. The block finishes the frame in progress, goes idle and raises a done flag. That flag stays set until the run bit is written to one again.

Top module: `lcd_raster_timing`

## Requirements
- R1: Horizontal register (address 0): active pixels minus one in bits 9:0, sync width minus one in bits 15:10, front porch minus one in bits 23:16, back porch minus one in bits 31:24.
- R2: Vertical register (address 1): active lines minus one in bits 9:0, sync width minus one in bits 15:10. Front porch (bits 23:16) and back porch (bits 31:24) are taken as written, so zero gives an empty porch.
- R3: The pixel period in logic clocks is the 8-bit divider field (address 2, bits 7:0), raised to 2 when the panel-type bit selects an active-matrix panel and to 3 for a passive panel.
- R4: While running, the horizontal count advances once per pixel period and wraps after sync+back+active+front pixels. The vertical count advances once per line and wraps after its four segments. Both counts read zero when idle.
- R5: Data-enable is active only where both counts lie inside their active segments. Syncs are active while the count lies inside the sync segment.
- R6: Polarity field (address 2, bits 25:20): bit 20 inverts vertical sync, bit 21 horizontal sync, bit 22 pixel clock, bit 23 data-enable. Bits 24 and 25 have no effect. Idle outputs sit at the inactive level, which is the polarity bit value.
- R7: Control register (address 3) bit 0 is run and bit 1 selects an active-matrix panel. Clearing run lets the current frame finish. The block goes idle on the clock edge that ends the last pixel of the frame, and the done flag rises on that same edge.
- R8: Writing run as one clears the done flag. Writing run as one again before the pending frame end cancels the stop, so the frames continue without a break.
- R9: For a passive panel, the AC-bias output toggles once for every N completed lines, where N is bits 15:8 of address 2. N of zero holds it low, and an active-matrix panel never toggles it.
- R10: After reset, all counts, the done flag and the AC-bias output are zero, and all other outputs are at their inactive level.
- R11: The raw pixel clock is high for the first floor(P/2) logic clocks of each pixel period P, and the position counters step on the clock edge that ends the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 horizontal, 1 vertical, 2 clock/polarity, 3 control |
| regWrData | input | 32 | Write data |
| lcdPclk | output | 1 | Pixel clock after polarity |
| lcdHsync | output | 1 | Horizontal sync after polarity |
| lcdVsync | output | 1 | Vertical sync after polarity |
| lcdDe | output | 1 | Data-enable after polarity |
| lcdAcBias | output | 1 | AC-bias toggle for passive panels |
| hCount | output | 12 | Pixel position within the line |
| vCount | output | 12 | Line position within the frame |
| frameDone | output | 1 | Set once a requested stop has completed |

## Verification
A behavioural model runs next to the design, and every output is compared on every clock. The first pattern is an active-matrix panel with a divider field of zero. It exposes the clamp to 2, the minus-one horizontal fields and non-zero vertical porches, across two full frames. The second is a passive panel with zero vertical porches, all polarity bits set and an AC-bias count of 2. It separates the minus-one fields from the as-written fields, tests inversion and the toggle cadence, and confirms that bits 24 and 25 do nothing. Further runs use an odd divider of 5 with a stop that is cancelled and then repeated, and a divider of 255 with a passive panel and an AC-bias count of zero. These check how the stop is timed against the frame end and how the done flag is set and cleared.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
  parameter int CNT_W = 12;
  parameter int DIV_W = 8;
  parameter int ACB_W = 8;
  parameter int POL_W = 6;

  // polarity bit indices inside the polarity field
  localparam int POL_VS   = 0;
  localparam int POL_HS   = 1;
  localparam int POL_PCLK = 2;
  localparam int POL_DE   = 3;
  localparam int N_SIG    = 4;

  // register field positions
  localparam int ACT_LSB = 0,  ACT_W = 10;
  localparam int SYN_LSB = 10, SYN_W = 6;
  localparam int FP_LSB  = 16, FP_W  = 8;
  localparam int BP_LSB  = 24, BP_W  = 8;
  localparam int ACB_LSB = 8;
  localparam int POL_LSB = 20;

  localparam logic [1:0] ADDR_H = 2'd0, ADDR_V = 2'd1, ADDR_CLK = 2'd2, ADDR_CTL = 2'd3;

  typedef struct packed {
    logic [CNT_W-1:0] hSync, hBack, hAct, hFront;
    logic [CNT_W-1:0] vSync, vBack, vAct, vFront;
    logic [DIV_W-1:0] div;
    logic [ACB_W-1:0] acbLines;
    logic             tft;
    logic [POL_W-1:0] pol;
  } cfg_t;

  typedef struct packed {
    logic run;
    logic pixEn;
    logic pclkHigh;
  } strobe_t;
endpackage

// File: rtl/lcd_raster_ctrl.sv
module lcd_raster_ctrl
  import lcd_raster_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  input  logic        frameEnd,
  output cfg_t        cfg,
  output strobe_t     stb,
  output logic        frameDone
);
  localparam logic [DIV_W-1:0] MIN_TFT = DIV_W'(2);
  localparam logic [DIV_W-1:0] MIN_PAS = DIV_W'(3);

  logic [31:0] hReg, vReg, cReg;
  logic        enReg, tftReg, running;
  logic [DIV_W-1:0] divCnt, minDiv;
  logic        ctlWr;

  assign ctlWr = regWr && (regAddr == ADDR_CTL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hReg <= '0; vReg <= '0; cReg <= '0;
      enReg <= 1'b0; tftReg <= 1'b0;
    end else if (regWr) begin
      case (regAddr)
        ADDR_H:   hReg <= regWrData;
        ADDR_V:   vReg <= regWrData;
        ADDR_CLK: cReg <= regWrData;
        default: begin
          enReg  <= regWrData[0];
          tftReg <= regWrData[1];
        end
      endcase
    end
  end

  // field decode: horizontal all minus-one, vertical porches as written
  always_comb begin
    cfg.hAct   = CNT_W'(hReg[ACT_LSB +: ACT_W]) + CNT_W'(1);
    cfg.hSync  = CNT_W'(hReg[SYN_LSB +: SYN_W]) + CNT_W'(1);
    cfg.hFront = CNT_W'(hReg[FP_LSB  +: FP_W])  + CNT_W'(1);
    cfg.hBack  = CNT_W'(hReg[BP_LSB  +: BP_W])  + CNT_W'(1);
    cfg.vAct   = CNT_W'(vReg[ACT_LSB +: ACT_W]) + CNT_W'(1);
    cfg.vSync  = CNT_W'(vReg[SYN_LSB +: SYN_W]) + CNT_W'(1);
    cfg.vFront = CNT_W'(vReg[FP_LSB  +: FP_W]);
    cfg.vBack  = CNT_W'(vReg[BP_LSB  +: BP_W]);
    minDiv     = tftReg ? MIN_TFT : MIN_PAS;
    cfg.div    = (cReg[DIV_W-1:0] < minDiv) ? minDiv : cReg[DIV_W-1:0];
    cfg.acbLines = cReg[ACB_LSB +: ACB_W];
    cfg.pol    = cReg[POL_LSB +: POL_W];
    cfg.tft    = tftReg;
  end

  assign stb.run      = running;
  assign stb.pixEn    = running && (divCnt == cfg.div - DIV_W'(1));
  assign stb.pclkHigh = running && (divCnt < (cfg.div >> 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      divCnt    <= '0;
      frameDone <= 1'b0;
    end else begin
      running <= running ? !(frameEnd && !enReg) : enReg;
      divCnt  <= (!running || stb.pixEn) ? '0 : divCnt + DIV_W'(1);
      if (ctlWr && regWrData[0])
        frameDone <= 1'b0;
      else if (running && frameEnd && !enReg)
        frameDone <= 1'b1;
    end
  end

  a_r3_pix_spacing: assert property (@(posedge clk) disable iff (!rstN)
    stb.pixEn |=> !stb.pixEn);
  a_r7_stop_at_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(frameEnd));
  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !running);
  a_r8_done_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && regWrData[0]) |=> !frameDone);
endmodule

// File: rtl/lcd_raster_dp.sv
module lcd_raster_dp
  import lcd_raster_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cfg_t             cfg,
  input  strobe_t          stb,
  output logic             lcdPclk,
  output logic             lcdHsync,
  output logic             lcdVsync,
  output logic             lcdDe,
  output logic             lcdAcBias,
  output logic [CNT_W-1:0] hCount,
  output logic [CNT_W-1:0] vCount,
  output logic             lineEnd,
  output logic             frameEnd
);
  logic [CNT_W-1:0] hCnt, vCnt, hLast, vLast, hActLo, hActHi, vActLo, vActHi;
  logic [ACB_W-1:0] lineAcc;
  logic             acbState;
  logic [N_SIG-1:0] rawSig, outSig;

  always_comb begin
    hActLo = cfg.hSync + cfg.hBack;
    hActHi = hActLo + cfg.hAct;
    hLast  = hActHi + cfg.hFront - CNT_W'(1);
    vActLo = cfg.vSync + cfg.vBack;
    vActHi = vActLo + cfg.vAct;
    vLast  = vActHi + cfg.vFront - CNT_W'(1);
  end

  assign lineEnd  = stb.pixEn && (hCnt == hLast);
  assign frameEnd = lineEnd && (vCnt == vLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0; vCnt <= '0; lineAcc <= '0; acbState <= 1'b0;
    end else if (!stb.run) begin
      hCnt <= '0; vCnt <= '0; lineAcc <= '0; acbState <= 1'b0;
    end else begin
      if (stb.pixEn) begin
        if (lineEnd) begin
          hCnt <= '0;
          vCnt <= frameEnd ? '0 : vCnt + CNT_W'(1);
        end else begin
          hCnt <= hCnt + CNT_W'(1);
        end
      end
      if (lineEnd && !cfg.tft && (cfg.acbLines != '0)) begin
        if (lineAcc == cfg.acbLines - ACB_W'(1)) begin
          lineAcc  <= '0;
          acbState <= !acbState;
        end else begin
          lineAcc <= lineAcc + ACB_W'(1);
        end
      end
    end
  end

  assign rawSig[POL_VS]   = stb.run && (vCnt < cfg.vSync);
  assign rawSig[POL_HS]   = stb.run && (hCnt < cfg.hSync);
  assign rawSig[POL_PCLK] = stb.pclkHigh;
  assign rawSig[POL_DE]   = stb.run && (hCnt >= hActLo) && (hCnt < hActHi)
                            && (vCnt >= vActLo) && (vCnt < vActHi);

  for (genvar i = 0; i < N_SIG; i++) begin : g_pol
    assign outSig[i] = rawSig[i] ^ cfg.pol[i];
  end

  assign lcdVsync  = outSig[POL_VS];
  assign lcdHsync  = outSig[POL_HS];
  assign lcdPclk   = outSig[POL_PCLK];
  assign lcdDe     = outSig[POL_DE];
  assign lcdAcBias = acbState;
  assign hCount    = hCnt;
  assign vCount    = vCnt;

  a_r4_h_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && !stb.pixEn) |=> $stable(hCnt));
  a_r4_v_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && !lineEnd) |=> $stable(vCnt));
  a_r5_de_outside_sync: assert property (@(posedge clk) disable iff (!rstN)
    rawSig[POL_DE] |-> (!rawSig[POL_HS] && !rawSig[POL_VS]));
  a_r9_acb_on_line: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && !lineEnd) |=> $stable(acbState));
endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
  import lcd_raster_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic             lcdPclk,
  output logic             lcdHsync,
  output logic             lcdVsync,
  output logic             lcdDe,
  output logic             lcdAcBias,
  output logic [CNT_W-1:0] hCount,
  output logic [CNT_W-1:0] vCount,
  output logic             frameDone
);
  cfg_t    cfg;
  strobe_t stb;
  logic    lineEnd, frameEnd;

  lcd_raster_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .frameEnd(frameEnd), .cfg(cfg), .stb(stb),
    .frameDone(frameDone)
  );

  lcd_raster_dp u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb),
    .lcdPclk(lcdPclk), .lcdHsync(lcdHsync), .lcdVsync(lcdVsync),
    .lcdDe(lcdDe), .lcdAcBias(lcdAcBias), .hCount(hCount), .vCount(vCount),
    .lineEnd(lineEnd), .frameEnd(frameEnd)
  );
endmodule

// File: tb/lcd_raster_timing_bench.sv
`timescale 1ns/1ps
module lcd_raster_timing_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic        lcdPclk, lcdHsync, lcdVsync, lcdDe, lcdAcBias, frameDone;
  logic [11:0] hCount, vCount;

  int nChecks = 0, nFail = 0;
  bit started = 0;

  always #2 clk = ~clk;

  lcd_raster_timing u_lcd_raster_timing (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .lcdPclk(lcdPclk), .lcdHsync(lcdHsync),
    .lcdVsync(lcdVsync), .lcdDe(lcdDe), .lcdAcBias(lcdAcBias),
    .hCount(hCount), .vCount(vCount), .frameDone(frameDone)
  );

  // reference model state
  int mRegH, mRegV, mRegC, mEn, mTft, mRun, mDone, mDc, mH, mV, mLa, mAcb;
  int mHsw, mHbp, mPpl, mHfp, mVsw, mVbp, mLpp, mVfp, mDiv, mAcn, mPol;
  int pe, le, fe, nRun, nDone;

  task automatic decode();
    mPpl = (mRegH & 1023) + 1;
    mHsw = ((mRegH >> 10) & 63) + 1;
    mHfp = ((mRegH >> 16) & 255) + 1;
    mHbp = ((mRegH >> 24) & 255) + 1;
    mLpp = (mRegV & 1023) + 1;
    mVsw = ((mRegV >> 10) & 63) + 1;
    mVfp = (mRegV >> 16) & 255;
    mVbp = (mRegV >> 24) & 255;
    mDiv = mRegC & 255;
    if (mDiv < (mTft ? 2 : 3)) mDiv = mTft ? 2 : 3;
    mAcn = (mRegC >> 8) & 255;
    mPol = (mRegC >> 20) & 63;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mRegH = 0; mRegV = 0; mRegC = 0; mEn = 0; mTft = 0; mRun = 0; mDone = 0;
      mDc = 0; mH = 0; mV = 0; mLa = 0; mAcb = 0;
    end else begin
      decode();
      pe = (mRun != 0) && (mDc == mDiv - 1);
      le = pe && (mH == mHsw + mHbp + mPpl + mHfp - 1);
      fe = le && (mV == mVsw + mVbp + mLpp + mVfp - 1);
      if (mRun == 0) begin
        mH = 0; mV = 0; mLa = 0; mAcb = 0;
      end else begin
        if (le && mTft == 0 && mAcn != 0) begin
          if (mLa == mAcn - 1) begin mLa = 0; mAcb = 1 - mAcb; end
          else mLa = mLa + 1;
        end
        if (pe) begin
          if (le) begin mH = 0; mV = fe ? 0 : mV + 1; end
          else mH = mH + 1;
        end
      end
      mDc = (mRun == 0 || pe) ? 0 : mDc + 1;
      nDone = mDone;
      if (mRun != 0 && fe && mEn == 0) nDone = 1;
      nRun = (mRun != 0) ? !(fe && mEn == 0) : mEn;
      if (regWr) begin
        case (regAddr)
          2'd0: mRegH = regWrData;
          2'd1: mRegV = regWrData;
          2'd2: mRegC = regWrData;
          default: begin
            mEn = regWrData[0]; mTft = regWrData[1];
            if (regWrData[0]) nDone = 0;
          end
        endcase
      end
      mRun = nRun; mDone = nDone;
      started = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every output every cycle, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      decode();
      chk("R1 R4 R5 R6 hsync", lcdHsync,
          ((mRun != 0 && mH < mHsw) ? 1 : 0) ^ (mPol & 1 ? 0 : 0) ^ ((mPol >> 1) & 1));
      chk("R2 R4 R5 R6 vsync", lcdVsync, ((mRun != 0 && mV < mVsw) ? 1 : 0) ^ (mPol & 1));
      chk("R3 R6 R11 pclk", lcdPclk, ((mRun != 0 && mDc < mDiv / 2) ? 1 : 0) ^ ((mPol >> 2) & 1));
      chk("R1 R2 R5 R6 de", lcdDe,
          ((mRun != 0 && mH >= mHsw + mHbp && mH < mHsw + mHbp + mPpl &&
            mV >= mVsw + mVbp && mV < mVsw + mVbp + mLpp) ? 1 : 0) ^ ((mPol >> 3) & 1));
      chk("R9 acbias", lcdAcBias, mAcb);
      chk("R1 R3 R4 R11 hCount", hCount, mH);
      chk("R2 R4 vCount", vCount, mV);
      chk("R7 R8 frameDone", frameDone, mDone);
    end
  end

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic waitDone(input int limit);
    for (int i = 0; i < limit && !frameDone; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state seen at the ports
    chk("R10 reset hCount", hCount, 0);
    chk("R10 reset frameDone", frameDone, 0);
    chk("R10 reset hsync", lcdHsync, 0);
    chk("R10 reset acbias", lcdAcBias, 0);
    rstN = 1'b1;

    // pattern 1: active-matrix, divider 0 clamped to 2, two frames
    wrReg(2'd0, 32'd3 | (32'd1 << 10) | (32'd0 << 16) | (32'd1 << 24));
    wrReg(2'd1, 32'd2 | (32'd0 << 10) | (32'd2 << 16) | (32'd1 << 24));
    wrReg(2'd2, 32'd0);
    wrReg(2'd3, 32'd3);
    repeat (270) @(negedge clk);
    wrReg(2'd3, 32'd2);
    waitDone(400);
    chk("R7 done after stop", frameDone, 1);
    chk("R7 idle hCount", hCount, 0);

    // pattern 2: passive, divider 1 clamped to 3, AC-bias 2, all polarity bits
    wrReg(2'd0, 32'd5 | (32'd2 << 10) | (32'd1 << 16));
    wrReg(2'd1, 32'd3 | (32'd1 << 10));
    wrReg(2'd2, 32'd1 | (32'd2 << 8) | (32'h3F << 20));
    chk("R6 idle hsync inactive", lcdHsync, 1);
    wrReg(2'd3, 32'd1);
    @(negedge clk);
    chk("R8 done cleared", frameDone, 0);
    repeat (530) @(negedge clk);
    wrReg(2'd3, 32'd0);
    waitDone(400);
    chk("R7 done passive", frameDone, 1);

    // pattern 3: divider 5, stop cancelled then repeated
    wrReg(2'd2, 32'd5 | (32'd3 << 8) | (32'h05 << 20));
    wrReg(2'd3, 32'd3);
    repeat (300) @(negedge clk);
    wrReg(2'd3, 32'd2);
    repeat (20) @(negedge clk);
    wrReg(2'd3, 32'd3);
    repeat (400) @(negedge clk);
    chk("R8 stop cancelled", frameDone, 0);
    wrReg(2'd3, 32'd2);
    waitDone(800);
    chk("R7 done after cancel", frameDone, 1);

    // pattern 4: passive, divider 255, AC-bias count 0 holds low
    wrReg(2'd2, 32'd255);
    wrReg(2'd3, 32'd1);
    repeat (1000) @(negedge clk);
    wrReg(2'd3, 32'd0);
    waitDone(20000);
    chk("R7 done slow divider", frameDone, 1);
    chk("R9 acbias held", lcdAcBias, 0);
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule